// File: doc/BRIEF.md
# Protocol Parameter Selection Responder

This block sits on the card side of a contact smart-card interface. It takes over the byte stream from the reader when a parameter-selection exchange starts, which happens right after the answer-to-reset. A command-phase controller owns the receive path by default. While the controller is waiting for a new command, the block watches for the selection start byte. Once that byte arrives, the block consumes the variable-length request and checks its trailing check byte. It then sends the request back unchanged as the card's acceptance.

The request length is set by three presence flags in the format byte. The response walks the same byte sequence out of the same storage slots, and a phase flag tells the two directions apart. When the echo finishes, the block strobes the negotiated clock-rate and baud-divisor indices to the baud generator. It also signals the controller to return to waiting for a command. A request with a bad check byte is dropped and gets no response. A wrapping counter records the number of exchanges that completed.

Top module: `pps_engine`

## Requirements
- R1: After reset, tx_valid_o, fidi_we_o and resume_o are 0, pps_count_o is 0, and fi_o and di_o are both 1.
- R2: A byte starts an exchange only if it is 0xFF and arrives while cmd_wait_i is high and no exchange is in progress. Any other byte, or 0xFF while cmd_wait_i is low, is ignored.
- R3: The request is taken in this order: start byte 0xFF, then the format byte, then optional bytes 1, 2 and 3, then the check byte. Optional byte 1 is present when format bit 4 is 1, byte 2 when bit 5 is 1, and byte 3 when bit 6 is 1. Absent bytes are skipped.
- R4: The check byte is valid when the XOR of every request byte, the check byte included, is 0x00. On a bad check byte, the cycle after it is accepted shows resume_o high for one cycle. In that case fidi_we_o stays 0, no response is sent, and fi_o, di_o and pps_count_o do not change.
- R5: After a valid check byte, tx_valid_o rises in the next cycle. The response then presents the request bytes in the same order and with the same presence rule. Each byte is held on tx_byte_o until tx_ready_i accepts it.
- R6: Bytes offered on rx_valid_i while the response is being sent are ignored.
- R7: In the cycle after the response check byte is accepted, fidi_we_o and resume_o are both high for one cycle and tx_valid_o is 0. fi_o takes the upper nibble of optional byte 1 and di_o its lower nibble. If byte 1 was absent, fi_o and di_o are both 1.
- R8: pps_count_o increments by one on each completed exchange and wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wait_i | input | 1 | Controller is waiting for the first byte of a command |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| tx_ready_i | input | 1 | Transmitter takes the presented byte |
| tx_valid_o | output | 1 | A response byte is presented |
| tx_byte_o | output | 8 | Response byte |
| fidi_we_o | output | 1 | One-cycle strobe: load fi_o/di_o into the baud generator |
| fi_o | output | 4 | Negotiated clock-rate index |
| di_o | output | 4 | Negotiated baud-divisor index |
| resume_o | output | 1 | One-cycle strobe: return to command phase |
| pps_count_o | output | CNT_W | Completed exchange count |

## Verification
The bench builds the block with CNT_W = 4. With that width, the exchange counter wraps from 15 back to 0 within a few dozen exchanges, so the wrap of R8 is reached without long runs. Random format bytes cover all eight combinations of optional bytes. Random gaps on the receive side and random back-pressure on the transmit side shift every handshake by varying amounts.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int unsigned SLOT_N = 6;
  localparam int unsigned IDX_W  = $clog2(SLOT_N);
  typedef logic [IDX_W-1:0] slot_idx_t;
  localparam slot_idx_t SL_START = 3'd0;
  localparam slot_idx_t SL_FMT   = 3'd1;
  localparam slot_idx_t SL_OPT1  = 3'd2;
  localparam slot_idx_t SL_OPT2  = 3'd3;
  localparam slot_idx_t SL_OPT3  = 3'd4;
  localparam slot_idx_t SL_CHK   = 3'd5;
  localparam logic [7:0] START_BYTE = 8'hFF;
endpackage

// File: rtl/pps_step.sv
module pps_step
  import pps_pkg::*;
(
  input  slot_idx_t  idx_i,
  input  logic [7:0] fmt_i,
  output slot_idx_t  nxt_o
);
  // skip absent optional bytes; after the check byte wrap to the start slot
  always_comb begin
    unique case (idx_i)
      SL_START: nxt_o = SL_FMT;
      SL_FMT:   nxt_o = fmt_i[4] ? SL_OPT1 : fmt_i[5] ? SL_OPT2 : fmt_i[6] ? SL_OPT3 : SL_CHK;
      SL_OPT1:  nxt_o = fmt_i[5] ? SL_OPT2 : fmt_i[6] ? SL_OPT3 : SL_CHK;
      SL_OPT2:  nxt_o = fmt_i[6] ? SL_OPT3 : SL_CHK;
      SL_OPT3:  nxt_o = SL_CHK;
      default:  nxt_o = SL_START;
    endcase
  end
endmodule

// File: rtl/pps_slots.sv
module pps_slots
  import pps_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  slot_idx_t  idx_i,
  input  logic [7:0] data_i,
  output logic [7:0] rd_data_o,
  output logic [7:0] fmt_o,
  output logic [7:0] opt1_o
);
  logic [7:0] slot_q [SLOT_N];

  for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          slot_q[g] <= 8'h00;
      else if (we_i && idx_i == slot_idx_t'(g)) slot_q[g] <= data_i;
    end
  end

  assign rd_data_o = (idx_i < slot_idx_t'(SLOT_N)) ? slot_q[idx_i] : 8'h00;
  assign fmt_o     = slot_q[SL_FMT];
  assign opt1_o    = slot_q[SL_OPT1];
endmodule

// File: rtl/pps_engine.sv
module pps_engine
  import pps_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_wait_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_byte_i,
  input  logic             tx_ready_i,
  output logic             tx_valid_o,
  output logic [7:0]       tx_byte_o,
  output logic             fidi_we_o,
  output logic [3:0]       fi_o,
  output logic [3:0]       di_o,
  output logic             resume_o,
  output logic [CNT_W-1:0] pps_count_o
);
  logic       resp_q;   // direction flag: 0 request, 1 response
  slot_idx_t  idx_q, idx_nxt;
  logic [7:0] chk_q, fmt_st, opt1_st, rd_byte, fmt_sel;
  logic       rx_take, tx_take, chk_ok;
  logic       fidi_we_q, resume_q;
  logic [3:0] fi_q, di_q;
  logic [CNT_W-1:0] cnt_q;

  assign rx_take = rx_valid_i && !resp_q &&
                   (idx_q != SL_START || (cmd_wait_i && rx_byte_i == START_BYTE));
  assign tx_take = resp_q && tx_ready_i;
  assign fmt_sel = (!resp_q && idx_q == SL_FMT) ? rx_byte_i : fmt_st;
  assign chk_ok  = (chk_q ^ rx_byte_i) == 8'h00;

  pps_slots i_slots (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rx_take),
    .idx_i     (idx_q),
    .data_i    (rx_byte_i),
    .rd_data_o (rd_byte),
    .fmt_o     (fmt_st),
    .opt1_o    (opt1_st)
  );

  pps_step i_step (
    .idx_i (idx_q),
    .fmt_i (fmt_sel),
    .nxt_o (idx_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_q    <= 1'b0;
      idx_q     <= SL_START;
      chk_q     <= 8'h00;
      fidi_we_q <= 1'b0;
      resume_q  <= 1'b0;
      fi_q      <= 4'd1;
      di_q      <= 4'd1;
      cnt_q     <= '0;
    end else begin
      fidi_we_q <= 1'b0;
      resume_q  <= 1'b0;
      if (rx_take) begin
        chk_q <= (idx_q == SL_START) ? rx_byte_i : (chk_q ^ rx_byte_i);
        if (idx_q == SL_CHK) begin
          idx_q <= SL_START;
          if (chk_ok) resp_q   <= 1'b1;
          else        resume_q <= 1'b1;
        end else begin
          idx_q <= idx_nxt;
        end
      end else if (tx_take) begin
        idx_q <= idx_nxt;
        if (idx_q == SL_CHK) begin
          resp_q    <= 1'b0;
          fidi_we_q <= 1'b1;
          resume_q  <= 1'b1;
          cnt_q     <= cnt_q + 1'b1;
          fi_q      <= fmt_st[4] ? opt1_st[7:4] : 4'd1;
          di_q      <= fmt_st[4] ? opt1_st[3:0] : 4'd1;
        end
      end
    end
  end

  assign tx_valid_o  = resp_q;
  assign tx_byte_o   = resp_q ? rd_byte : 8'h00;
  assign fidi_we_o   = fidi_we_q;
  assign resume_o    = resume_q;
  assign fi_o        = fi_q;
  assign di_o        = di_q;
  assign pps_count_o = cnt_q;
endmodule

// File: rtl/pps_engine_chk.sv
module pps_engine_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_ready_i,
  input logic             tx_valid_o,
  input logic [7:0]       tx_byte_o,
  input logic             fidi_we_o,
  input logic [3:0]       fi_o,
  input logic [3:0]       di_o,
  input logic             resume_o,
  input logic [CNT_W-1:0] pps_count_o
);
  // R5
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_byte_o));
  // R7
  done_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fidi_we_o |-> resume_o && !tx_valid_o);
  // R7
  fidi_only_on_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fi_o != $past(fi_o) || di_o != $past(di_o)) |-> fidi_we_o);
  // R8
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fidi_we_o |-> pps_count_o == CNT_W'($past(pps_count_o) + 1'b1));
  // R4
  count_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pps_count_o != $past(pps_count_o)) |-> fidi_we_o);
  // R7
  resume_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !resume_o);
endmodule

bind pps_engine pps_engine_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_pps_engine.sv
`timescale 1ns/1ps
module test_pps_engine;
  localparam int unsigned CNT_W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_wait_i = 1'b1, rx_valid_i = 1'b0, tx_ready_i = 1'b0;
  logic [7:0] rx_byte_i = 8'h00;
  logic tx_valid_o, fidi_we_o, resume_o;
  logic [7:0] tx_byte_o;
  logic [3:0] fi_o, di_o;
  logic [CNT_W-1:0] pps_count_o;

  int checks = 0, fails = 0;
  logic [3:0] exp_fi = 4'd1, exp_di = 4'd1;
  logic [CNT_W-1:0] exp_cnt = '0;
  logic [7:0] req [6];
  int req_n;

  always #2 clk = ~clk;

  pps_engine #(.CNT_W(CNT_W)) i_pps_engine (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_wait_i(cmd_wait_i),
    .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i), .tx_ready_i(tx_ready_i),
    .tx_valid_o(tx_valid_o), .tx_byte_o(tx_byte_o), .fidi_we_o(fidi_we_o),
    .fi_o(fi_o), .di_o(di_o), .resume_o(resume_o), .pps_count_o(pps_count_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // bench model of a request: start, format, present options, check byte
  function automatic int build_req(input logic [7:0] fmt, input logic [7:0] o1,
                                   input logic [7:0] o2, input logic [7:0] o3,
                                   input bit corrupt);
    int n = 0;
    logic [7:0] x;
    req[n++] = 8'hFF;
    req[n++] = fmt;
    if (fmt[4]) req[n++] = o1;
    if (fmt[5]) req[n++] = o2;
    if (fmt[6]) req[n++] = o3;
    x = 8'h00;
    for (int i = 0; i < n; i++) x ^= req[i];
    if (corrupt) x ^= 8'(1 << ($urandom % 8));
    req[n++] = x;
    return n;
  endfunction

  task automatic send_byte(input logic [7:0] b);
    repeat ($urandom % 3) @(negedge clk);
    rx_valid_i = 1'b1;
    rx_byte_i  = b;
    @(negedge clk);
    rx_valid_i = 1'b0;
  endtask

  task automatic run_pps(input logic [7:0] fmt, input logic [7:0] o1, input bit corrupt,
                         input bit noise);
    req_n = build_req(fmt, o1, 8'($urandom), 8'($urandom), corrupt);
    for (int i = 0; i < req_n; i++) send_byte(req[i]);
    if (corrupt) begin
      check(resume_o && !fidi_we_o && !tx_valid_o, "R4 bad check byte", {resume_o, fidi_we_o, tx_valid_o}, 3'b100);
      @(negedge clk);
      check(!tx_valid_o && fi_o == exp_fi && di_o == exp_di && pps_count_o == exp_cnt,
            "R4 state kept", {tx_valid_o, fi_o, di_o}, {1'b0, exp_fi, exp_di});
      return;
    end
    check(tx_valid_o, "R5 response starts", tx_valid_o, 1);
    for (int i = 0; i < req_n; ) begin
      @(negedge clk);
      if (noise) begin
        rx_valid_i = $urandom % 2;
        rx_byte_i  = ($urandom % 2) ? 8'hFF : 8'($urandom);
      end
      tx_ready_i = $urandom % 2;
      if (!tx_valid_o) begin
        check(0, "R5 tx_valid dropped", 0, 1);
        break;
      end
      if (tx_ready_i) begin
        check(tx_byte_o == req[i], noise ? "R6 echo under rx noise" : "R3 R5 echo byte", tx_byte_o, req[i]);
        i++;
      end
    end
    @(negedge clk);
    tx_ready_i = 1'b0;
    rx_valid_i = 1'b0;
    if (fmt[4]) begin exp_fi = o1[7:4]; exp_di = o1[3:0]; end
    else        begin exp_fi = 4'd1;    exp_di = 4'd1;    end
    exp_cnt = exp_cnt + 1'b1;
    check(fidi_we_o && resume_o && !tx_valid_o, "R7 done strobes", {fidi_we_o, resume_o, tx_valid_o}, 3'b110);
    check(fi_o == exp_fi && di_o == exp_di, "R7 fi/di", {fi_o, di_o}, {exp_fi, exp_di});
    check(pps_count_o == exp_cnt, "R8 count", pps_count_o, exp_cnt);
    @(negedge clk);
    check(!fidi_we_o && !resume_o, "R7 single-cycle strobes", {fidi_we_o, resume_o}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0101));
    repeat (3) @(negedge clk);
    // R1
    check(!tx_valid_o && !fidi_we_o && !resume_o && pps_count_o == 0 && fi_o == 1 && di_o == 1,
          "R1 reset state", {tx_valid_o, fidi_we_o, resume_o, fi_o, di_o}, 8'h11);
    rst_ni = 1'b1;
    @(negedge clk);
    // R2: non-start byte and start byte outside command wait are ignored
    send_byte(8'h00);
    cmd_wait_i = 1'b0;
    send_byte(8'hFF);
    check(!tx_valid_o && !resume_o, "R2 ignored bytes", {tx_valid_o, resume_o}, 0);
    cmd_wait_i = 1'b1;
    run_pps(8'h00, 8'h00, 0, 0);            // R3 minimal request
    run_pps(8'h71, 8'h96, 0, 0);            // R3 all options present
    run_pps(8'h21, 8'h00, 0, 0);            // R3 only byte 2
    run_pps(8'h11, 8'h13, 1, 0);            // R4 bad check byte
    run_pps(8'h51, 8'h94, 0, 1);            // R6 rx noise in response
    for (int k = 0; k < 40; k++) begin      // R8 wraps at 16
      logic [7:0] f;
      f = {1'b0, 3'($urandom), 4'($urandom)};
      run_pps(f, 8'($urandom), ($urandom % 6) == 0, $urandom % 2);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule